// File: doc/BRIEF.md
# Stack Call/Return Sequencer

This block moves the stack traffic of a small 8-bit processor. It handles subroutine call and return, interrupt entry and return, and single-byte push and pop of the accumulator and of the status byte. It owns the 8-bit stack pointer. Every stack address it issues has the page-select bit as its high byte and the stack pointer as its low byte, so the stack sits in page 0 or page 1.

A controller presents a command with the current program counter, accumulator, status byte, vector address and page select, and pulses `cmd_valid`. The block then raises `busy` and makes at most one access per clock on a synchronous memory port. A read returns its data two edges after the address is issued. When the sequence ends, the block pulses `done` for one cycle. At that point `pc_out`, `acc_out` and `ps_out` hold the restored or updated values, and `sp` holds the new stack pointer.

Writes decrement the pointer after the store. Reads increment it before the load. A maskable interrupt is refused when the interrupt-disable flag is set. A break request is never refused, and it stores the status byte with its break bit at 1. The live status output always shows the break bit as 0.

Top module: `stack_seq`

## Requirements
- R1: Every stack access uses address {7'b0, page, S}: bits 15:8 equal the page-select bit (0x00 or 0x01) and bits 7:0 come from the stack pointer.
- R2: Call (cmd_op 0) writes PC[15:8] at the current S, then PC[7:0] at S-1, and leaves S decreased by 2.
- R3: Return (cmd_op 1) reads PC[7:0] from S+1, then PC[15:8] from S+2, loads `pc_out` from them, and leaves S increased by 2.
- R4: A taken interrupt (cmd_op 2) writes PC[15:8], PC[7:0] and the status byte at S, S-1 and S-2. It then reads the vector's low byte at `vec_addr` and its high byte at `vec_addr`+1, loads `pc_out` from them, and sets status bit 2 (interrupt disable) in `ps_out`. The vector reads leave S unchanged.
- R5: Interrupt return (cmd_op 4) reads the status byte at S+1, PC[7:0] at S+2 and PC[15:8] at S+3, restores them, and leaves S increased by 3.
- R6: An interrupt request (cmd_op 2) whose `ps_in` bit 2 is 1 makes no memory access and leaves S and `pc_out` unchanged. A break request (cmd_op 3) runs the full entry sequence whatever bit 2 holds.
- R7: A break request stores the status byte with bit 4 forced to 1. Bit 4 of `ps_out` reads 0 at all times, including after a restore of a byte that has bit 4 set.
- R8: Push accumulator (5) and push status (6) write one byte at S, then decrement S. Pop accumulator (7) and pop status (8) increment S, then read there. Push status stores `ps_in` with bit 4 cleared.
- R9: S wraps modulo 256 and never carries into the page byte. A pop at S=0xFF reads offset 0x00 of the selected page.
- R10: The block makes at most one memory access per clock. `busy` is high from the cycle after a command is accepted until `done`, and `done` is a one-cycle pulse with `busy` low. A `cmd_valid` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start a command when idle |
| cmd_op | input | 4 | Command code: 0 call, 1 return, 2 interrupt, 3 break, 4 interrupt return, 5 push acc, 6 push status, 7 pop acc, 8 pop status |
| page_sel | input | 1 | Stack page select (0 or 1) |
| pc_in | input | 16 | Current program counter |
| acc_in | input | 8 | Current accumulator |
| ps_in | input | 8 | Current status byte |
| vec_addr | input | 16 | Address of the interrupt vector's low byte |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_rdata | input | 8 | Read data, valid the cycle after the memory samples the address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| sp | output | 8 | Stack pointer |
| pc_out | output | 16 | Resulting program counter |
| acc_out | output | 8 | Resulting accumulator |
| ps_out | output | 8 | Resulting status byte (bit 4 always 0) |

## Verification
A stack pointer that is off by one shows up on the very next access as a wrong low address byte. A wrong step order shows up as bytes stored in swapped slots, which a later return turns into a wrong `pc_out`. A stale read-tag pipeline drops a byte, or lands it in the wrong field, two cycles after the read is issued, and this is seen at `done`. A wrong masking or break-bit decision appears in the same command, either as accesses that should not happen or as a wrong stored status byte.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [3:0] {
    OP_JSR = 4'd0,
    OP_RTS = 4'd1,
    OP_IRQ = 4'd2,
    OP_BRK = 4'd3,
    OP_RTI = 4'd4,
    OP_PHA = 4'd5,
    OP_PHP = 4'd6,
    OP_PLA = 4'd7,
    OP_PLP = 4'd8
  } op_e;

  // byte field a step moves
  typedef enum logic [2:0] {
    FLD_NONE = 3'd0,
    FLD_PCL  = 3'd1,
    FLD_PCH  = 3'd2,
    FLD_ACC  = 3'd3,
    FLD_PS   = 3'd4
  } fld_e;

  // kind of memory access a step performs
  typedef enum logic [1:0] {
    K_PUSH = 2'd0,
    K_POP  = 2'd1,
    K_VEC  = 2'd2
  } kind_e;

  typedef struct packed {
    logic  vld;
    kind_e kind;
    fld_e  fld;
  } step_t;

  localparam int BRK_BIT  = 4;
  localparam int IDIS_BIT = 2;

endpackage

// File: rtl/stack_seq_ucode.sv
module stack_seq_ucode
  import stack_seq_pkg::*;
#(
  parameter int IW = 3
) (
  input  op_e           op,
  input  logic [IW-1:0] idx,
  output step_t         step
);
  localparam int NSLOT = 1 << IW;

  step_t prog [NSLOT];

  function automatic step_t mk(input kind_e k, input fld_e f);
    step_t s;
    s.vld  = 1'b1;
    s.kind = k;
    s.fld  = f;
    return s;
  endfunction

  always_comb begin
    for (int i = 0; i < NSLOT; i++) prog[i] = '0;
    case (op)
      OP_JSR: begin
        prog[0] = mk(K_PUSH, FLD_PCH);
        prog[1] = mk(K_PUSH, FLD_PCL);
      end
      OP_RTS: begin
        prog[0] = mk(K_POP, FLD_PCL);
        prog[1] = mk(K_POP, FLD_PCH);
      end
      OP_IRQ, OP_BRK: begin
        prog[0] = mk(K_PUSH, FLD_PCH);
        prog[1] = mk(K_PUSH, FLD_PCL);
        prog[2] = mk(K_PUSH, FLD_PS);
        prog[3] = mk(K_VEC,  FLD_PCL);
        prog[4] = mk(K_VEC,  FLD_PCH);
      end
      OP_RTI: begin
        prog[0] = mk(K_POP, FLD_PS);
        prog[1] = mk(K_POP, FLD_PCL);
        prog[2] = mk(K_POP, FLD_PCH);
      end
      OP_PHA: prog[0] = mk(K_PUSH, FLD_ACC);
      OP_PHP: prog[0] = mk(K_PUSH, FLD_PS);
      OP_PLA: prog[0] = mk(K_POP,  FLD_ACC);
      OP_PLP: prog[0] = mk(K_POP,  FLD_PS);
      default: ;
    endcase
    step = prog[idx];
  end

endmodule

// File: rtl/stack_seq_addr.sv
module stack_seq_addr
  import stack_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  kind_e           kind,
  input  fld_e            fld,
  input  logic            page,
  input  logic [DW-1:0]   sp_cur,
  input  logic [2*DW-1:0] vec,
  output logic [2*DW-1:0] addr,
  output logic [DW-1:0]   sp_nxt,
  output logic            on_stack
);
  localparam int AW = 2 * DW;

  logic [DW-1:0] pg_hi;
  logic [DW-1:0] sp_inc;
  logic [DW-1:0] sp_dec;

  assign pg_hi  = DW'(page);
  assign sp_inc = sp_cur + DW'(1);
  assign sp_dec = sp_cur - DW'(1);

  always_comb begin
    case (kind)
      K_PUSH: begin
        addr     = {pg_hi, sp_cur};
        sp_nxt   = sp_dec;
        on_stack = 1'b1;
      end
      K_POP: begin
        addr     = {pg_hi, sp_inc};
        sp_nxt   = sp_inc;
        on_stack = 1'b1;
      end
      default: begin
        addr     = vec + AW'(fld == FLD_PCH);
        sp_nxt   = sp_cur;
        on_stack = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/stack_seq_regs.sv
module stack_seq_regs
  import stack_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            set_idis,
  input  logic [2*DW-1:0] pc_in,
  input  logic [DW-1:0]   acc_in,
  input  logic [DW-1:0]   ps_in,
  input  logic            cap,
  input  fld_e            cap_fld,
  input  logic [DW-1:0]   cap_data,
  output logic [2*DW-1:0] pc_q,
  output logic [DW-1:0]   acc_q,
  output logic [DW-1:0]   ps_q
);
  localparam logic [DW-1:0] BRK_MASK  = DW'(1) << BRK_BIT;
  localparam logic [DW-1:0] IDIS_MASK = DW'(1) << IDIS_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      acc_q <= '0;
      ps_q  <= '0;
    end else if (load) begin
      pc_q  <= pc_in;
      acc_q <= acc_in;
      ps_q  <= (ps_in & ~BRK_MASK) | (set_idis ? IDIS_MASK : '0);
    end else if (cap) begin
      case (cap_fld)
        FLD_PCL: pc_q[DW-1:0]    <= cap_data;
        FLD_PCH: pc_q[2*DW-1:DW] <= cap_data;
        FLD_ACC: acc_q           <= cap_data;
        FLD_PS:  ps_q            <= cap_data & ~BRK_MASK;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int            DW       = 8,
  parameter int            IW       = 3,
  parameter logic [DW-1:0] SP_RESET = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic            page_sel,
  input  logic [2*DW-1:0] pc_in,
  input  logic [DW-1:0]   acc_in,
  input  logic [DW-1:0]   ps_in,
  input  logic [2*DW-1:0] vec_addr,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_en,
  output logic            mem_we,
  input  logic [DW-1:0]   mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   sp,
  output logic [2*DW-1:0] pc_out,
  output logic [DW-1:0]   acc_out,
  output logic [DW-1:0]   ps_out
);
  localparam int            AW       = 2 * DW;
  localparam logic [DW-1:0] BRK_MASK = DW'(1) << BRK_BIT;

  op_e             op_q;
  op_e             cmd_op_e;
  logic            page_q;
  logic [AW-1:0]   pc_q;
  logic [DW-1:0]   acc_q;
  logic [DW-1:0]   psw_q;
  logic [AW-1:0]   vec_q;
  logic [DW-1:0]   sp_q;
  logic [IW-1:0]   idx_q;
  logic            skip_q;
  logic            busy_q;
  logic            done_q;
  logic            stk_q;
  fld_e            t1_q;
  fld_e            t2_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            en_q;
  logic            we_q;

  step_t           step;
  logic            issue;
  logic [AW-1:0]   a_addr;
  logic [DW-1:0]   a_sp;
  logic            a_stk;
  logic [DW-1:0]   wd;
  logic            start;
  logic            masked;
  logic            cap;

  assign cmd_op_e = op_e'(cmd_op);
  assign start    = !busy_q && cmd_valid;
  assign masked   = (cmd_op_e == OP_IRQ) && ps_in[IDIS_BIT];

  stack_seq_ucode #(.IW(IW)) u_ucode (
    .op   (op_q),
    .idx  (idx_q),
    .step (step)
  );

  assign issue = busy_q && step.vld && !skip_q;

  stack_seq_addr #(.DW(DW)) u_addr (
    .kind     (step.kind),
    .fld      (step.fld),
    .page     (page_q),
    .sp_cur   (sp_q),
    .vec      (vec_q),
    .addr     (a_addr),
    .sp_nxt   (a_sp),
    .on_stack (a_stk)
  );

  always_comb begin
    case (step.fld)
      FLD_PCH: wd = pc_q[AW-1:DW];
      FLD_PCL: wd = pc_q[DW-1:0];
      FLD_ACC: wd = acc_q;
      FLD_PS:  wd = psw_q;
      default: wd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_JSR;
      page_q  <= 1'b0;
      pc_q    <= '0;
      acc_q   <= '0;
      psw_q   <= '0;
      vec_q   <= '0;
      sp_q    <= SP_RESET;
      idx_q   <= '0;
      skip_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      stk_q   <= 1'b0;
      t1_q    <= FLD_NONE;
      t2_q    <= FLD_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
      en_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      en_q   <= 1'b0;
      we_q   <= 1'b0;
      t1_q   <= FLD_NONE;
      t2_q   <= t1_q;
      if (start) begin
        busy_q <= 1'b1;
        op_q   <= cmd_op_e;
        page_q <= page_sel;
        pc_q   <= pc_in;
        acc_q  <= acc_in;
        vec_q  <= vec_addr;
        idx_q  <= '0;
        skip_q <= masked;
        psw_q  <= (cmd_op_e == OP_BRK) ? (ps_in | BRK_MASK) : (ps_in & ~BRK_MASK);
      end else if (issue) begin
        en_q    <= 1'b1;
        we_q    <= (step.kind == K_PUSH);
        addr_q  <= a_addr;
        wdata_q <= wd;
        stk_q   <= a_stk;
        sp_q    <= a_sp;
        idx_q   <= idx_q + IW'(1);
        if (step.kind != K_PUSH) t1_q <= step.fld;
      end else if (busy_q && t1_q == FLD_NONE && t2_q == FLD_NONE) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign cap = busy_q && (t2_q != FLD_NONE);

  stack_seq_regs #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .set_idis (((cmd_op_e == OP_IRQ) && !masked) || (cmd_op_e == OP_BRK)),
    .pc_in    (pc_in),
    .acc_in   (acc_in),
    .ps_in    (ps_in),
    .cap      (cap),
    .cap_fld  (t2_q),
    .cap_data (mem_rdata),
    .pc_q     (pc_out),
    .acc_q    (acc_out),
    .ps_q     (ps_out)
  );

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_en    = en_q;
  assign mem_we    = we_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign sp        = sp_q;

  // R1: stack accesses carry the page in the high byte
  p_page_byte_r1: assert property (@(posedge clk) disable iff (rst)
    (en_q && stk_q) |-> (addr_q[AW-1:DW] == DW'(page_q)));

  // R2: a write lands at the pointer value before its decrement
  p_wr_post_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (en_q && we_q) |-> (addr_q[DW-1:0] == sp_q + DW'(1)));

  // R3: a stack read lands at the pointer value after its increment
  p_rd_pre_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (en_q && !we_q && stk_q) |-> (addr_q[DW-1:0] == sp_q));

  // R4: vector reads leave the pointer untouched
  p_vec_sp_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (en_q && !stk_q) |-> $stable(sp_q));

  // R6: a refused interrupt makes no access
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && skip_q) |-> !en_q);

  // R10: no access while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !en_q);

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R10: done only when no longer busy
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

endmodule

// File: tb/stack_seq_bench.sv
module stack_seq_bench;
  import stack_seq_pkg::*;

  localparam int DW = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [3:0]    cmd_op = '0;
  logic          page_sel = 1'b0;
  logic [AW-1:0] pc_in = '0;
  logic [DW-1:0] acc_in = '0;
  logic [DW-1:0] ps_in = '0;
  logic [AW-1:0] vec_addr = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_en;
  logic          mem_we;
  logic [DW-1:0] mem_rdata = '0;
  logic          busy;
  logic          done;
  logic [DW-1:0] sp;
  logic [AW-1:0] pc_out;
  logic [DW-1:0] acc_out;
  logic [DW-1:0] ps_out;

  always #5 clk = ~clk;

  stack_seq #(.DW(DW)) u_stack_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .page_sel(page_sel), .pc_in(pc_in), .acc_in(acc_in), .ps_in(ps_in),
    .vec_addr(vec_addr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .sp(sp), .pc_out(pc_out),
    .acc_out(acc_out), .ps_out(ps_out)
  );

  logic [7:0] mem     [65536];
  logic [7:0] ref_mem [65536];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  typedef struct packed {
    logic [15:0] a;
    logic        we;
    logic [7:0]  d;
  } acc_t;

  acc_t  exp_q[$];
  acc_t  mon_x;
  int    n_run = 0;
  int    n_fail = 0;
  bit    finished = 0;
  logic [7:0] sp_m = 8'hFF;
  string cur_req = "R10";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic void e_push(input logic pg, input logic [7:0] d);
    acc_t x;
    x.a = {7'b0, pg, sp_m};
    x.we = 1'b1;
    x.d = d;
    exp_q.push_back(x);
    ref_mem[x.a] = d;
    sp_m = sp_m - 8'd1;
  endfunction

  function automatic logic [7:0] e_pop(input logic pg);
    acc_t x;
    sp_m = sp_m + 8'd1;
    x.a = {7'b0, pg, sp_m};
    x.we = 1'b0;
    x.d = '0;
    exp_q.push_back(x);
    return ref_mem[x.a];
  endfunction

  function automatic logic [7:0] e_rd(input logic [15:0] a);
    acc_t x;
    x.a = a;
    x.we = 1'b0;
    x.d = '0;
    exp_q.push_back(x);
    return ref_mem[a];
  endfunction

  // monitor: every access the design makes must match the next expected item
  always @(negedge clk) begin
    if (!rst && mem_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected access at", int'(mem_addr), 0);
      end else begin
        mon_x = exp_q.pop_front();
        chk(mem_addr == mon_x.a, cur_req, "access address", int'(mem_addr), int'(mon_x.a));
        chk(mem_we == mon_x.we, cur_req, "access direction", int'(mem_we), int'(mon_x.we));
        if (mon_x.we)
          chk(mem_wdata == mon_x.d, cur_req, "stored byte", int'(mem_wdata), int'(mon_x.d));
      end
    end
  end

  task automatic run(input op_e op, input logic pg, input logic [15:0] pc,
                     input logic [7:0] acc, input logic [7:0] ps,
                     input logic [15:0] vec, input string req, input bit inject);
    logic [15:0] e_pc;
    logic [7:0]  e_acc;
    logic [7:0]  e_ps;
    logic [7:0]  lo;
    logic [7:0]  hi;
    int          wd;
    cur_req = req;
    e_pc  = pc;
    e_acc = acc;
    e_ps  = ps & 8'hEF;
    case (op)
      OP_JSR: begin
        e_push(pg, pc[15:8]);
        e_push(pg, pc[7:0]);
      end
      OP_RTS: begin
        lo = e_pop(pg);
        hi = e_pop(pg);
        e_pc = {hi, lo};
      end
      OP_IRQ, OP_BRK: begin
        if (!(op == OP_IRQ && ps[2])) begin
          e_push(pg, pc[15:8]);
          e_push(pg, pc[7:0]);
          e_push(pg, (op == OP_BRK) ? (ps | 8'h10) : (ps & 8'hEF));
          lo = e_rd(vec);
          hi = e_rd(vec + 16'd1);
          e_pc = {hi, lo};
          e_ps = e_ps | 8'h04;
        end
      end
      OP_RTI: begin
        e_ps = e_pop(pg) & 8'hEF;
        lo = e_pop(pg);
        hi = e_pop(pg);
        e_pc = {hi, lo};
      end
      OP_PHA: e_push(pg, acc);
      OP_PHP: e_push(pg, ps & 8'hEF);
      OP_PLA: e_acc = e_pop(pg);
      OP_PLP: e_ps = e_pop(pg) & 8'hEF;
      default: ;
    endcase

    cmd_valid = 1'b1;
    cmd_op    = op;
    page_sel  = pg;
    pc_in     = pc;
    acc_in    = acc;
    ps_in     = ps;
    vec_addr  = vec;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R10", "busy after accept", int'(busy), 1);
    if (inject) begin
      cmd_valid = 1'b1;
      cmd_op    = OP_PHA;
      acc_in    = 8'h77;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    wd = 0;
    while (!done && wd < 100) begin
      @(negedge clk);
      wd++;
    end
    chk(done == 1'b1, req, "done seen", int'(done), 1);
    chk(pc_out == e_pc, req, "pc_out", int'(pc_out), int'(e_pc));
    chk(acc_out == e_acc, req, "acc_out", int'(acc_out), int'(e_acc));
    chk(ps_out == e_ps, req, "ps_out", int'(ps_out), int'(e_ps));
    chk(sp == sp_m, req, "stack pointer", int'(sp), int'(sp_m));
    chk(exp_q.size() == 0, req, "accesses still missing", exp_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done width", int'(done), 0);
    chk(busy == 1'b0, "R10", "idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 65536; i++) begin
      mem[i]     = 8'(i) ^ 8'(i >> 8) ^ 8'h3C;
      ref_mem[i] = 8'(i) ^ 8'(i >> 8) ^ 8'h3C;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sp == 8'hFF, "R9", "reset pointer", int'(sp), 8'hFF);
    chk(busy == 1'b0, "R10", "reset busy", int'(busy), 0);
    chk(done == 1'b0, "R10", "reset done", int'(done), 0);
    chk(mem_en == 1'b0, "R10", "reset strobe", int'(mem_en), 0);

    run(OP_PLA, 1'b1, 16'h0000, 8'h00, 8'h00, 16'h0000, "R9 R1", 1'b0);
    run(OP_PHA, 1'b1, 16'h0000, 8'hA5, 8'h00, 16'h0000, "R9 R8", 1'b0);
    run(OP_JSR, 1'b0, 16'h1234, 8'h00, 8'h00, 16'h0000, "R1 R2", 1'b0);
    run(OP_RTS, 1'b0, 16'h0000, 8'h00, 8'h00, 16'h0000, "R3", 1'b0);
    run(OP_IRQ, 1'b0, 16'hBEEF, 8'h11, 8'h81, 16'hFFFC, "R4", 1'b0);
    run(OP_RTI, 1'b0, 16'h0000, 8'h11, 8'h00, 16'h0000, "R5", 1'b0);
    run(OP_IRQ, 1'b0, 16'h5566, 8'h22, 8'h04, 16'hFFFC, "R6", 1'b0);
    run(OP_BRK, 1'b0, 16'h4321, 8'h22, 8'h04, 16'hFFFE, "R6 R7", 1'b0);
    run(OP_PHP, 1'b0, 16'h0000, 8'h00, 8'h3F, 16'h0000, "R8 R7", 1'b0);
    run(OP_PLP, 1'b0, 16'h0000, 8'h00, 8'h00, 16'h0000, "R8", 1'b0);
    run(OP_PLP, 1'b0, 16'h0000, 8'h00, 8'hFF, 16'h0000, "R7", 1'b0);
    run(OP_JSR, 1'b1, 16'h9ABC, 8'h33, 8'h00, 16'h0000, "R10", 1'b1);
    run(OP_PHA, 1'b0, 16'h0000, 8'hC3, 8'h00, 16'h0000, "R8", 1'b0);
    run(OP_PLA, 1'b0, 16'h0000, 8'h00, 8'h00, 16'h0000, "R8", 1'b0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "trailing accesses", exp_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule